// File: doc/BRIEF.md
# Per-Field Caption Line Data Serializer

This block places two data bytes on one chosen video line of each enabled field, in the way a closed-caption data slot is built. A host writes a byte pair for odd fields, a second pair for even fields, and a two-bit field-enable setting. The video timing side supplies a field identity, a one-cycle line-start strobe and the current line number. When the line number matches the programmed target line and the current field is enabled, the block waits a programmed number of clocks. It then sends a clock run-in, a framing code and the sixteen data bits as a one-bit digital level, with a flag that marks the active window.

Each byte goes out least significant bit first. The most significant bit of each byte is the host's parity bit, and the block sends it as written. Bytes, enable and bit period are captured when a burst is accepted, so host writes made during a burst take effect on the next one. Waveform shaping, DAC drive and parity generation are left to later stages.

The controller is a state machine with five states. `ST_IDLE` waits for a qualified strobe. `ST_WAIT` counts down the start delay. `ST_RUNIN` sends the seven run-in bits. `ST_FRAME` sends the three framing bits. `ST_DATA` sends the sixteen data bits. The transitions are:
- IDLE to WAIT on a qualified strobe with a non-zero delay.
- IDLE to RUNIN on a qualified strobe with zero delay.
- WAIT to RUNIN when the delay count reaches one.
- RUNIN to FRAME at the end of the seventh bit.
- FRAME to DATA at the end of the tenth bit.
- DATA to IDLE at the end of the twenty-sixth bit.

Top module: `cap_line_ser`

## Requirements
- R1: Writes with `wr_en` high store `wr_data` by `wr_addr`:
  - address 0 is the first odd-field byte, 1 the second odd-field byte;
  - address 2 is the first even-field byte, 3 the second even-field byte;
  - address 4 stores `wr_data[1:0]` as the field enable;
  - addresses 5 to 7 change nothing.
- R2: Enable bit 0 permits bursts in field 1 (`field_id`=0, odd) and enable bit 1 permits bursts in field 2 (`field_id`=1, even). The value 00 disables both fields and 11 enables both.
- R3: A burst begins with seven run-in bits 1,0,1,0,1,0,1, followed by the framing bits 0,0,1.
- R4: A burst is exactly 26 bit periods long, and `cc_active` stays high without a gap for 26 × P clocks.
- R5: A burst starts only when `line_strobe` is sampled high, `line_num` equals `cfg_line` and the field is enabled. If the strobe is sampled at clock edge t0, `cc_active` first goes high after edge t0 + `cfg_delay`.
- R6: Every bit lasts P = `cfg_bit_clks` clocks. A value of 0 is treated as 1.
- R7: After the framing bits come the first byte and then the second byte, each sent LSB first, with bit 7 sent unchanged.
- R8: After reset, and at any time no burst is running, `cc_data` and `cc_active` are 0. All registers reset to zero.
- R9: The bytes, enable and bit period are captured at the accepted strobe. Register writes and further strobes during a burst do not alter the burst in progress.
- R10: `field_id`=0 selects the odd-field pair and `field_id`=1 selects the even-field pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host register select |
| wr_data | input | 8 | Host write data |
| cfg_line | input | LINE_W | Target line number |
| cfg_delay | input | DLY_W | Clocks from accepted strobe to first bit |
| cfg_bit_clks | input | PER_W | Clocks per bit (0 acts as 1) |
| field_id | input | 1 | 0 = field 1 (odd), 1 = field 2 (even) |
| line_strobe | input | 1 | One-cycle line-start pulse |
| line_num | input | LINE_W | Current line number |
| cc_data | output | 1 | Serial data level |
| cc_active | output | 1 | High during the burst window |

## Verification
The assertions assume the following about the inputs:
- `cfg_delay` does not change while the block is counting down the start delay.
- `line_strobe` is a single-cycle pulse.

Period, bytes and enable need no such care, because they are captured at the start of a burst. The stimulus changes configuration only while the block is idle and drives every strobe for exactly one clock. The one deliberate exception is a register write and a repeated strobe issued in the middle of a burst, which checks that both are ignored.

// File: rtl/cap_line_pkg.sv
package cap_line_pkg;

    localparam int RUNIN_BITS = 7;
    localparam int FRAME_BITS = 3;
    localparam int BYTE_BITS  = 8;
    localparam int DATA_BITS  = 2 * BYTE_BITS;
    localparam int TOTAL_BITS = RUNIN_BITS + FRAME_BITS + DATA_BITS;
    localparam int IDX_W      = $clog2(TOTAL_BITS);

    // framing code, element 0 goes out first: 0, 0, 1
    localparam logic [FRAME_BITS-1:0] FRAME_CODE = 3'b100;

    localparam logic [2:0] ADDR_ODD_A  = 3'd0;
    localparam logic [2:0] ADDR_ODD_B  = 3'd1;
    localparam logic [2:0] ADDR_EVEN_A = 3'd2;
    localparam logic [2:0] ADDR_EVEN_B = 3'd3;
    localparam logic [2:0] ADDR_ENABLE = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RUNIN,
        ST_FRAME,
        ST_DATA
    } cap_state_t;

    typedef struct packed {
        logic [BYTE_BITS-1:0] second;
        logic [BYTE_BITS-1:0] first;
    } byte_pair_t;

endpackage

// File: rtl/cap_host_regs.sv
module cap_host_regs
    import cap_line_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output byte_pair_t odd_pair,
    output byte_pair_t even_pair,
    output logic [1:0] field_en
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            odd_pair  <= '0;
            even_pair <= '0;
            field_en  <= 2'b00;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_ODD_A:  odd_pair.first   <= wr_data;
                ADDR_ODD_B:  odd_pair.second  <= wr_data;
                ADDR_EVEN_A: even_pair.first  <= wr_data;
                ADDR_EVEN_B: even_pair.second <= wr_data;
                ADDR_ENABLE: field_en         <= wr_data[1:0];
                default: ;
            endcase
        end
    end

    // R1: enable changes only through its own address
    p_en_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADDR_ENABLE) |=> $stable(field_en));

    // R1: odd pair changes only through its two addresses
    p_odd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == ADDR_ODD_A || wr_addr == ADDR_ODD_B)) |=> $stable(odd_pair));

endmodule

// File: rtl/cap_pattern_build.sv
module cap_pattern_build
    import cap_line_pkg::*;
(
    input  byte_pair_t            pair,
    output logic [TOTAL_BITS-1:0] pattern
);

    localparam int DATA_LSB = RUNIN_BITS + FRAME_BITS;

    for (genvar i = 0; i < RUNIN_BITS; i++) begin : g_runin
        assign pattern[i] = ((i % 2) == 0);
    end

    for (genvar k = 0; k < FRAME_BITS; k++) begin : g_frame
        assign pattern[RUNIN_BITS + k] = FRAME_CODE[k];
    end

    assign pattern[DATA_LSB +: BYTE_BITS]             = pair.first;
    assign pattern[DATA_LSB + BYTE_BITS +: BYTE_BITS] = pair.second;

endmodule

// File: rtl/cap_bit_timer.sv
module cap_bit_timer #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] period,
    output logic             tick
);

    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] eff;

    assign eff  = (period == '0) ? PER_W'(1) : period;
    assign tick = run && (cnt_q == eff - PER_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PER_W'(1);
        end
    end

    // R6: the in-bit count never passes the period
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < eff));

endmodule

// File: rtl/cap_line_ser.sv
module cap_line_ser
    import cap_line_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int DLY_W  = 12,
    parameter int PER_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [LINE_W-1:0] cfg_line,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic [PER_W-1:0]  cfg_bit_clks,
    input  logic              field_id,
    input  logic              line_strobe,
    input  logic [LINE_W-1:0] line_num,
    output logic              cc_data,
    output logic              cc_active
);

    localparam int CYC_W = PER_W + IDX_W + 1;

    byte_pair_t            odd_pair, even_pair, sel_pair;
    logic [1:0]            field_en;
    logic [TOTAL_BITS-1:0] pattern;

    cap_state_t            state_q, state_d;
    logic [TOTAL_BITS-1:0] shreg_q;
    logic [IDX_W-1:0]      bit_idx_q;
    logic [DLY_W-1:0]      dly_q;
    logic [PER_W-1:0]      per_q;
    logic                  fld_q;
    logic [1:0]            en_q;
    logic                  field_ok, start, in_burst, bit_tick;

    cap_host_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .odd_pair (odd_pair),
        .even_pair(even_pair),
        .field_en (field_en)
    );

    assign sel_pair = field_id ? even_pair : odd_pair;

    cap_pattern_build u_pat (
        .pair   (sel_pair),
        .pattern(pattern)
    );

    assign in_burst = (state_q == ST_RUNIN) || (state_q == ST_FRAME) || (state_q == ST_DATA);

    cap_bit_timer #(.PER_W(PER_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_burst),
        .period(per_q),
        .tick  (bit_tick)
    );

    assign field_ok = field_id ? field_en[1] : field_en[0];
    assign start    = (state_q == ST_IDLE) && line_strobe && (line_num == cfg_line) && field_ok;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = (cfg_delay == '0) ? ST_RUNIN : ST_WAIT;
            ST_WAIT:  if (dly_q == DLY_W'(1)) state_d = ST_RUNIN;
            ST_RUNIN: if (bit_tick && bit_idx_q == IDX_W'(RUNIN_BITS - 1)) state_d = ST_FRAME;
            ST_FRAME: if (bit_tick && bit_idx_q == IDX_W'(RUNIN_BITS + FRAME_BITS - 1)) state_d = ST_DATA;
            ST_DATA:  if (bit_tick && bit_idx_q == IDX_W'(TOTAL_BITS - 1)) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and burst datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            shreg_q   <= '0;
            bit_idx_q <= '0;
            dly_q     <= '0;
            per_q     <= '0;
            fld_q     <= 1'b0;
            en_q      <= 2'b00;
        end else begin
            state_q <= state_d;
            if (start) begin
                shreg_q   <= pattern;
                bit_idx_q <= '0;
                dly_q     <= cfg_delay;
                per_q     <= cfg_bit_clks;
                fld_q     <= field_id;
                en_q      <= field_en;
            end else if (state_q == ST_WAIT) begin
                dly_q <= dly_q - DLY_W'(1);
            end else if (in_burst && bit_tick) begin
                shreg_q   <= shreg_q >> 1;
                bit_idx_q <= bit_idx_q + IDX_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RUNIN, ST_FRAME, ST_DATA: begin
                cc_active = 1'b1;
                cc_data   = shreg_q[0];
            end
            default: begin
                cc_active = 1'b0;
                cc_data   = 1'b0;
            end
        endcase
    end

    // checker-side burst length counter
    logic [CYC_W-1:0] burst_cyc;
    logic [PER_W-1:0] per_eff;
    assign per_eff = (per_q == '0) ? PER_W'(1) : per_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         burst_cyc <= '0;
        else if (start)     burst_cyc <= '0;
        else if (cc_active) burst_cyc <= burst_cyc + CYC_W'(1);
    end

    // R3: the first burst bit is a run-in one
    p_rise_is_runin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_active) |-> cc_data);

    // R8: data stays low outside the window
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_active |-> !cc_data);

    // R4: a finished burst covered 26 bit periods
    p_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cc_active) |-> (burst_cyc == CYC_W'(TOTAL_BITS) * CYC_W'(per_eff)));

    // R6: the level holds until the bit period ends
    p_bit_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_active && !bit_tick) |=> (cc_active && $stable(cc_data)));

    // R2: a burst only runs for a field its captured enable allows
    p_enable_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_active) |-> (fld_q ? en_q[1] : en_q[0]));

    // R9: a strobe during a burst leaves the captured data untouched
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_burst && !bit_tick) |=> $stable(shreg_q));

endmodule

// File: tb/tb_cap_line_ser.sv
`timescale 1ns/1ps
module tb_cap_line_ser;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [9:0] cfg_line;
    logic [11:0] cfg_delay;
    logic [7:0] cfg_bit_clks;
    logic       field_id;
    logic       line_strobe;
    logic [9:0] line_num;
    logic       cc_data;
    logic       cc_active;

    always #2.5 clk = ~clk;

    cap_line_ser dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_line(cfg_line), .cfg_delay(cfg_delay), .cfg_bit_clks(cfg_bit_clks),
        .field_id(field_id), .line_strobe(line_strobe), .line_num(line_num),
        .cc_data(cc_data), .cc_active(cc_active)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [7:0] m_odd0, m_odd1, m_even0, m_even1;
    logic [1:0] m_en;

    typedef struct packed {
        logic       fld;
        logic [1:0] en;
        logic [7:0] o0;
        logic [7:0] o1;
        logic [7:0] e0;
        logic [7:0] e1;
        logic [7:0] per;
        logic [11:0] dly;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 2'b01, 8'hA5, 8'h3C, 8'h11, 8'h22, 8'd2, 12'd3},
        '{1'b1, 2'b01, 8'hA5, 8'h3C, 8'h11, 8'h22, 8'd2, 12'd3},
        '{1'b1, 2'b10, 8'h0F, 8'hF0, 8'h96, 8'h69, 8'd3, 12'd0},
        '{1'b0, 2'b10, 8'h0F, 8'hF0, 8'h96, 8'h69, 8'd3, 12'd0},
        '{1'b0, 2'b11, 8'h80, 8'h01, 8'h55, 8'hAA, 8'd1, 12'd1},
        '{1'b1, 2'b11, 8'h80, 8'h01, 8'hFF, 8'h00, 8'd4, 12'd7},
        '{1'b0, 2'b00, 8'hC3, 8'h3C, 8'h12, 8'h34, 8'd2, 12'd2},
        '{1'b1, 2'b00, 8'hC3, 8'h3C, 8'h12, 8'h34, 8'd2, 12'd2}
    };

    // expected bit k of a burst, from R3 and R7
    function automatic logic exp_bit(input logic [7:0] b0, input logic [7:0] b1, input int k);
        if (k < 7)       return (k % 2) == 0;
        else if (k < 10) return k == 9;
        else if (k < 18) return b0[k - 10];
        else             return b1[k - 18];
    endfunction

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            3'd0: m_odd0  = d;
            3'd1: m_odd1  = d;
            3'd2: m_even0 = d;
            3'd3: m_even1 = d;
            3'd4: m_en    = d[1:0];
            default: ;
        endcase
    endtask

    task automatic run_burst(input bit exp_on, input logic fld, input logic [7:0] b0,
                             input logic [7:0] b1, input int per, input int dly,
                             input bit line_ok, input bit disturb, input string tag);
        int p_eff;
        int bad;
        int bad_j;
        logic ea, ed, ga, gd, xa, xd;
        p_eff = (per == 0) ? 1 : per;
        bad = 0; bad_j = 0; ga = 0; gd = 0; xa = 0; xd = 0;
        field_id = fld; cfg_bit_clks = 8'(per); cfg_delay = 12'(dly);
        @(negedge clk);
        line_strobe = 1'b1;
        line_num = line_ok ? cfg_line : cfg_line + 10'd1;
        @(negedge clk);
        line_strobe = 1'b0;
        for (int j = 0; j < dly + 26 * p_eff + 4; j++) begin
            ea = exp_on && (j >= dly) && (j < dly + 26 * p_eff);
            ed = ea && exp_bit(b0, b1, (j - dly) / p_eff);
            if (cc_active !== ea || cc_data !== ed) begin
                if (bad == 0) begin
                    bad_j = j; ga = cc_active; gd = cc_data; xa = ea; xd = ed;
                end
                bad++;
            end
            if (disturb && j == dly + 5) begin
                wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'hFF;
                line_strobe = 1'b1; line_num = cfg_line;
            end else if (disturb && j == dly + 6) begin
                wr_en = 1'b0; line_strobe = 1'b0;
            end
            @(negedge clk);
        end
        if (disturb) m_odd0 = 8'hFF;
        n_tests++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s: cycle %0d active,data=%b%b expected %b%b", tag, bad_j, ga, gd, xa, xd);
        end
    endtask

    task automatic check_idle(input string tag);
        n_tests++;
        if (cc_active !== 1'b0 || cc_data !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: active,data=%b%b expected 00", tag, cc_active, cc_data);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R4 watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        cfg_line = 10'd21; cfg_delay = '0; cfg_bit_clks = 8'd1;
        field_id = 1'b0; line_strobe = 1'b0; line_num = '0;
        m_odd0 = 0; m_odd1 = 0; m_even0 = 0; m_even1 = 0; m_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R8 reset state");

        // table walk: R2, R3, R4, R6, R7, R10
        for (int v = 0; v < 8; v++) begin
            write_reg(3'd0, VECS[v].o0);
            write_reg(3'd1, VECS[v].o1);
            write_reg(3'd2, VECS[v].e0);
            write_reg(3'd3, VECS[v].e1);
            write_reg(3'd4, {6'd0, VECS[v].en});
            run_burst(VECS[v].en[VECS[v].fld], VECS[v].fld,
                      VECS[v].fld ? VECS[v].e0 : VECS[v].o0,
                      VECS[v].fld ? VECS[v].e1 : VECS[v].o1,
                      int'(VECS[v].per), int'(VECS[v].dly), 1'b1, 1'b0,
                      $sformatf("R2/R3/R4/R7/R10 vector %0d", v));
        end

        // R5: wrong line number gives no burst
        write_reg(3'd4, 8'h03);
        run_burst(1'b0, 1'b0, m_odd0, m_odd1, 2, 1, 1'b0, 1'b0, "R5 line mismatch");

        // R6: period zero behaves as one
        run_burst(1'b1, 1'b0, m_odd0, m_odd1, 0, 2, 1'b1, 1'b0, "R6 zero period");

        // R9: write and strobe during a burst
        write_reg(3'd0, 8'h5A);
        write_reg(3'd1, 8'hC3);
        write_reg(3'd4, 8'h01);
        run_burst(1'b1, 1'b0, 8'h5A, 8'hC3, 2, 4, 1'b1, 1'b1, "R9 mid-burst write");
        run_burst(1'b1, 1'b0, m_odd0, m_odd1, 1, 0, 1'b1, 1'b0, "R1 write lands after burst");

        // R1: unused addresses change nothing
        write_reg(3'd5, 8'h00);
        write_reg(3'd6, 8'h00);
        write_reg(3'd7, 8'h00);
        run_burst(1'b1, 1'b0, m_odd0, m_odd1, 3, 2, 1'b1, 1'b0, "R1 unused address");

        check_idle("R8 idle after bursts");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule